// File: doc/BRIEF.md
# Banked memory page mapper

This block steers every CPU access in a 64 KiB, 8-bit address space to the storage that should serve it. The space holds two copies of general RAM (main and auxiliary), a page of I/O, a window of peripheral or internal ROM, a system ROM, and a bank-switched high RAM. The high RAM exists in two copies. Each copy has two alternative banks for the lower 4 KiB of the area and one shared region above them. Routing works one 256-byte page at a time, and it depends on whether the access is a read or a write. Reads and writes to the same page can therefore reach different storage.

A set of mode inputs comes from control registers that live outside this block. Those inputs pick the auxiliary copy for low memory, split the display pages out of the global selection, choose the ROM for the peripheral window, and open the high RAM for reads and for writes. The block drives three outputs:
- a one-hot region select,
- a bank code that identifies one high-RAM copy,
- a flag that is set when a write actually lands.

A parameter selects the output timing. The outputs are either combinational or registered one cycle behind the access.

Top module: `mem_page_router`

## Requirements
- R1: Page 0xC0 always selects I/O (region bit 2) for reads and writes. A write there sets `wr_ok_o`.
- R2: Pages 0x00–0x01 use auxiliary RAM for both reads and writes when `alt_low` is 1, and main RAM when it is 0. The global aux selects have no effect on these pages.
- R3: For pages 0x02–0xBF, a read goes to auxiliary RAM exactly when `sel_aux_rd` is 1, and a write goes there exactly when `sel_aux_wr` is 1. The two selects act independently of each other.
- R4: While `disp_split` is 1, pages 0x04–0x07 follow `disp_pg2` for both directions: 1 selects auxiliary RAM and 0 selects main RAM. This overrides the global selects. While `disp_split` is 0, these pages follow R3.
- R5: While `disp_split` is 1, pages 0x20–0x3F behave as follows:
  - With `disp_gfx` at 1, they follow `disp_pg2` as in R4.
  - With `disp_gfx` at 0 and `disp_pg2` at 1, they select main RAM.
  - With both at 0, they follow R3.
- R6: Reads of pages 0xC1–0xCF select the internal ROM (bit 4) when `cx_internal` is 1, and the slot ROM (bit 3) otherwise. Writes to these pages are dropped: region 0 and `wr_ok_o` 0.
- R7: Reads of pages 0xD0–0xFF select high RAM (bit 6) when `hi_rd_ram` is 1, and system ROM (bit 5) when it is 0.
- R8: Writes to pages 0xD0–0xFF are dropped (region 0, `wr_ok_o` 0) unless `hi_wr_ram` is 1. When it is 1, they land in high RAM with the same bank code a read would get.
- R9: For high RAM, `bank_o[1:0]` encodes the section:
  - 1 is the first lower bank (pages 0xD0–0xDF with `hi_bank1` at 1).
  - 2 is the second lower bank (pages 0xD0–0xDF with `hi_bank1` at 0).
  - 3 is the shared upper region (pages 0xE0–0xFF).

  `bank_o[2]` equals `alt_low` and selects the auxiliary copy. For every other region, `bank_o` is 0.
- R10: `region_o` has at most one bit set. The bits are: 0 main RAM, 1 aux RAM, 2 I/O, 3 slot ROM, 4 internal ROM, 5 system ROM, 6 high RAM. `wr_ok_o` is 1 only for a write that lands, and it is 0 for every read.
- R11: With `REG_OUT` = 1, the outputs appear on the rising edge after the access and are all 0 during reset. With `REG_OUT` = 0, they follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output variant |
| rst_n | input | 1 | Active-low reset of the output registers |
| addr_page | input | PAGE_W (8) | Page number: upper byte of the CPU address |
| wr | input | 1 | 1 for a write access, 0 for a read |
| sel_aux_rd | input | 1 | Global aux select for reads of general RAM |
| sel_aux_wr | input | 1 | Global aux select for writes of general RAM |
| alt_low | input | 1 | Aux copy for zero page, stack and high RAM |
| disp_split | input | 1 | Display pages routed by the page flag |
| disp_pg2 | input | 1 | Display page flag |
| disp_gfx | input | 1 | Graphics display flag |
| cx_internal | input | 1 | Peripheral window reads the internal ROM |
| hi_rd_ram | input | 1 | High area reads from RAM instead of ROM |
| hi_wr_ram | input | 1 | High area accepts writes |
| hi_bank1 | input | 1 | Lower high bank 1 selected (else bank 2) |
| region_o | output | 7 | One-hot target region |
| bank_o | output | 3 | High-RAM copy and section code |
| wr_ok_o | output | 1 | Write lands in the selected region |

## Verification
The combinational instance has its results due in the same cycle as the access. The registered instance has them due one rising edge later. The bench drives each access on a falling edge and checks the combinational outputs 1 ns afterwards. It then waits for the next falling edge, so exactly one rising edge has loaded the output registers, and checks the registered outputs there. Inputs are held over that whole window, so neither result can mix two accesses. The clocked properties in the design use the same one-edge offset by relating an access to the outputs on the following edge.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   localparam int RGN_N    = 7;
   localparam int RGN_MAIN = 0;
   localparam int RGN_AUX  = 1;
   localparam int RGN_IO   = 2;
   localparam int RGN_SLOT = 3;
   localparam int RGN_INT  = 4;
   localparam int RGN_SYS  = 5;
   localparam int RGN_HI   = 6;

   typedef logic [RGN_N-1:0] rgn_t;

   localparam logic [1:0] HSEC_NONE = 2'd0;
   localparam logic [1:0] HSEC_LO1  = 2'd1;
   localparam logic [1:0] HSEC_LO2  = 2'd2;
   localparam logic [1:0] HSEC_UP   = 2'd3;

   typedef struct packed {
      rgn_t       region;
      logic       bank_aux;
      logic [1:0] bank_sec;
      logic       wr_ok;
   } route_t;

   localparam int ROUTE_W = $bits(route_t);

   function automatic rgn_t rgn_bit(input int idx);
      rgn_t v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/mpr_low_route.sv
module mpr_low_route
   import mpr_pkg::*;
#(
   parameter int unsigned          PAGE_W    = 8,
   parameter logic [PAGE_W-1:0]    STACK_TOP = 'h02,
   parameter logic [PAGE_W-1:0]    TXT_FIRST = 'h04,
   parameter logic [PAGE_W-1:0]    TXT_LAST  = 'h07,
   parameter logic [PAGE_W-1:0]    GFX_FIRST = 'h20,
   parameter logic [PAGE_W-1:0]    GFX_LAST  = 'h3F
) (
   input  logic [PAGE_W-1:0] page,
   input  logic              wr,
   input  logic              sel_aux_rd,
   input  logic              sel_aux_wr,
   input  logic              alt_low,
   input  logic              disp_split,
   input  logic              disp_pg2,
   input  logic              disp_gfx,
   output route_t            rt
);

   logic in_stack;
   logic in_txt;
   logic in_gfx;
   logic global_aux;
   logic use_aux;

   always_comb begin
      in_stack   = (page < STACK_TOP);
      in_txt     = (page >= TXT_FIRST) && (page <= TXT_LAST);
      in_gfx     = (page >= GFX_FIRST) && (page <= GFX_LAST);
      global_aux = wr ? sel_aux_wr : sel_aux_rd;

      // display override ranks above the global selects
      use_aux = global_aux;
      if (in_stack)
         use_aux = alt_low;
      else if (disp_split && in_txt)
         use_aux = disp_pg2;
      else if (disp_split && in_gfx && disp_gfx)
         use_aux = disp_pg2;
      else if (disp_split && in_gfx && disp_pg2)
         use_aux = 1'b0;

      rt        = '0;
      rt.region = use_aux ? rgn_bit(RGN_AUX) : rgn_bit(RGN_MAIN);
      rt.wr_ok  = wr;
   end

endmodule

// File: rtl/mpr_high_route.sv
module mpr_high_route
   import mpr_pkg::*;
#(
   parameter int unsigned          PAGE_W   = 8,
   parameter logic [PAGE_W-1:0]    IO_PAGE  = 'hC0,
   parameter logic [PAGE_W-1:0]    CX_LAST  = 'hCF,
   parameter logic [PAGE_W-1:0]    HI_UPPER = 'hE0
) (
   input  logic [PAGE_W-1:0] page,
   input  logic              wr,
   input  logic              alt_low,
   input  logic              cx_internal,
   input  logic              hi_rd_ram,
   input  logic              hi_wr_ram,
   input  logic              hi_bank1,
   output route_t            rt
);

   logic hi_ram;

   always_comb begin
      hi_ram = wr ? hi_wr_ram : hi_rd_ram;
      rt     = '0;
      if (page == IO_PAGE) begin
         rt.region = rgn_bit(RGN_IO);
         rt.wr_ok  = wr;
      end else if (page <= CX_LAST) begin
         // ROM window: writes fall through with no target
         if (!wr)
            rt.region = cx_internal ? rgn_bit(RGN_INT) : rgn_bit(RGN_SLOT);
      end else if (hi_ram) begin
         rt.region   = rgn_bit(RGN_HI);
         rt.bank_aux = alt_low;
         if (page >= HI_UPPER)
            rt.bank_sec = HSEC_UP;
         else
            rt.bank_sec = hi_bank1 ? HSEC_LO1 : HSEC_LO2;
         rt.wr_ok    = wr;
      end else if (!wr) begin
         rt.region = rgn_bit(RGN_SYS);
      end
   end

endmodule

// File: rtl/mpr_out_stage.sv
module mpr_out_stage
   import mpr_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  route_t d,
   output route_t q
);

   generate
      if (REG_OUT) begin : g_reg
         route_t q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q_r <= '0;
            else
               q_r <= d;
         end
         assign q = q_r;
      end else begin : g_comb
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/mem_page_router.sv
module mem_page_router
   import mpr_pkg::*;
#(
   parameter int unsigned          PAGE_W    = 8,
   parameter logic [PAGE_W-1:0]    STACK_TOP = 'h02,
   parameter logic [PAGE_W-1:0]    TXT_FIRST = 'h04,
   parameter logic [PAGE_W-1:0]    TXT_LAST  = 'h07,
   parameter logic [PAGE_W-1:0]    GFX_FIRST = 'h20,
   parameter logic [PAGE_W-1:0]    GFX_LAST  = 'h3F,
   parameter logic [PAGE_W-1:0]    IO_PAGE   = 'hC0,
   parameter logic [PAGE_W-1:0]    CX_LAST   = 'hCF,
   parameter logic [PAGE_W-1:0]    HI_UPPER  = 'hE0,
   parameter bit                   REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] addr_page,
   input  logic              wr,
   input  logic              sel_aux_rd,
   input  logic              sel_aux_wr,
   input  logic              alt_low,
   input  logic              disp_split,
   input  logic              disp_pg2,
   input  logic              disp_gfx,
   input  logic              cx_internal,
   input  logic              hi_rd_ram,
   input  logic              hi_wr_ram,
   input  logic              hi_bank1,
   output logic [6:0]        region_o,
   output logic [2:0]        bank_o,
   output logic              wr_ok_o
);

   localparam logic [PAGE_W-1:0] HI_LOWER = CX_LAST + 1'b1;

   generate
      if (PAGE_W < 8) begin : g_bad_width
         $error("mem_page_router: PAGE_W must be at least 8");
      end
      if (!(STACK_TOP <= TXT_FIRST && TXT_FIRST <= TXT_LAST && TXT_LAST < GFX_FIRST &&
            GFX_FIRST <= GFX_LAST && GFX_LAST < IO_PAGE && IO_PAGE < CX_LAST &&
            CX_LAST < HI_UPPER)) begin : g_bad_map
         $error("mem_page_router: page boundaries out of order");
      end
      if (RGN_N != 7) begin : g_bad_rgn
         $error("mem_page_router: region width mismatch");
      end
   endgenerate

   route_t rt_low;
   route_t rt_high;
   route_t rt_pick;
   route_t rt_out;

   mpr_low_route #(
      .PAGE_W(PAGE_W), .STACK_TOP(STACK_TOP), .TXT_FIRST(TXT_FIRST),
      .TXT_LAST(TXT_LAST), .GFX_FIRST(GFX_FIRST), .GFX_LAST(GFX_LAST)
   ) u_low (
      .page(addr_page), .wr(wr), .sel_aux_rd(sel_aux_rd), .sel_aux_wr(sel_aux_wr),
      .alt_low(alt_low), .disp_split(disp_split), .disp_pg2(disp_pg2),
      .disp_gfx(disp_gfx), .rt(rt_low)
   );

   mpr_high_route #(
      .PAGE_W(PAGE_W), .IO_PAGE(IO_PAGE), .CX_LAST(CX_LAST), .HI_UPPER(HI_UPPER)
   ) u_high (
      .page(addr_page), .wr(wr), .alt_low(alt_low), .cx_internal(cx_internal),
      .hi_rd_ram(hi_rd_ram), .hi_wr_ram(hi_wr_ram), .hi_bank1(hi_bank1),
      .rt(rt_high)
   );

   assign rt_pick = (addr_page >= IO_PAGE) ? rt_high : rt_low;

   mpr_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .d(rt_pick), .q(rt_out)
   );

   assign region_o = rt_out.region;
   assign bank_o   = {rt_out.bank_aux, rt_out.bank_sec};
   assign wr_ok_o  = rt_out.wr_ok;

   generate
      if (REG_OUT) begin : g_chk
         AST_IO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_page == IO_PAGE) |=> (region_o == rgn_bit(RGN_IO)))
            else $error("I/O page not routed to I/O"); // R1
         AST_ZP_ALT: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_page < STACK_TOP && alt_low) |=> (region_o == rgn_bit(RGN_AUX)))
            else $error("low pages ignore aux copy"); // R2
         AST_CX_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr_page > IO_PAGE && addr_page <= CX_LAST) |=> (region_o == '0 && !wr_ok_o))
            else $error("ROM window write not dropped"); // R6
         AST_HI_RD_ROM: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr && addr_page >= HI_LOWER && !hi_rd_ram) |=> (region_o == rgn_bit(RGN_SYS)))
            else $error("high read not from system ROM"); // R7
         AST_HI_WR_PROT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr_page >= HI_LOWER && !hi_wr_ram) |=> !wr_ok_o)
            else $error("protected high write landed"); // R8
         AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !region_o[RGN_HI] |-> (bank_o == 3'd0))
            else $error("bank code outside high RAM"); // R9
         AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(region_o))
            else $error("more than one region selected"); // R10
         AST_READ_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
            !wr |=> !wr_ok_o)
            else $error("write flag on a read"); // R10
      end
   endgenerate

endmodule

// File: tb/mem_page_router_test.sv
`timescale 1ns/1ps
module mem_page_router_test;

   localparam logic [6:0] E_NONE = 7'h00;
   localparam logic [6:0] E_MAIN = 7'h01;
   localparam logic [6:0] E_AUX  = 7'h02;
   localparam logic [6:0] E_IO   = 7'h04;
   localparam logic [6:0] E_SLOT = 7'h08;
   localparam logic [6:0] E_INT  = 7'h10;
   localparam logic [6:0] E_SYS  = 7'h20;
   localparam logic [6:0] E_HI   = 7'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] pg = 8'h00;
   logic wr = 1'b0;
   logic m_aux_rd = 0, m_aux_wr = 0, m_alt = 0, m_split = 0, m_pg2 = 0, m_gfx = 0;
   logic m_cx = 0, m_hrd = 0, m_hwr = 0, m_hb1 = 0;

   logic [6:0] r_reg, r_cmb;
   logic [2:0] b_reg, b_cmb;
   logic       o_reg, o_cmb;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mem_page_router #(.REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .addr_page(pg), .wr(wr),
      .sel_aux_rd(m_aux_rd), .sel_aux_wr(m_aux_wr), .alt_low(m_alt),
      .disp_split(m_split), .disp_pg2(m_pg2), .disp_gfx(m_gfx),
      .cx_internal(m_cx), .hi_rd_ram(m_hrd), .hi_wr_ram(m_hwr), .hi_bank1(m_hb1),
      .region_o(r_reg), .bank_o(b_reg), .wr_ok_o(o_reg)
   );

   mem_page_router #(.REG_OUT(1'b0)) uut_comb (
      .clk(clk), .rst_n(rst_n), .addr_page(pg), .wr(wr),
      .sel_aux_rd(m_aux_rd), .sel_aux_wr(m_aux_wr), .alt_low(m_alt),
      .disp_split(m_split), .disp_pg2(m_pg2), .disp_gfx(m_gfx),
      .cx_internal(m_cx), .hi_rd_ram(m_hrd), .hi_wr_ram(m_hwr), .hi_bank1(m_hb1),
      .region_o(r_cmb), .bank_o(b_cmb), .wr_ok_o(o_cmb)
   );

   task automatic compare(input string req, input string which,
                          input logic [6:0] ar, input logic [2:0] ab, input logic ao,
                          input logic [6:0] er, input logic [2:0] eb, input logic eo);
      checks++;
      if (ar !== er || ab !== eb || ao !== eo) begin
         errors++;
         $display("FAIL %s %s page=%h wr=%0b: actual region=%h bank=%0d ok=%0b expected region=%h bank=%0d ok=%0b",
                  req, which, pg, wr, ar, ab, ao, er, eb, eo);
      end
   endtask

   // combinational result same cycle, registered one rising edge later (R11)
   task automatic probe(input logic [7:0] p, input logic w,
                        input logic [6:0] er, input logic [2:0] eb, input logic eo,
                        input string req);
      @(negedge clk);
      pg = p;
      wr = w;
      #1;
      compare(req, "comb", r_cmb, b_cmb, o_cmb, er, eb, eo);
      @(negedge clk);
      compare(req, "reg", r_reg, b_reg, o_reg, er, eb, eo);
   endtask

   task automatic modes(input logic ard, input logic awr, input logic alt,
                        input logic spl, input logic p2, input logic gfx);
      m_aux_rd = ard; m_aux_wr = awr; m_alt = alt;
      m_split = spl; m_pg2 = p2; m_gfx = gfx;
   endtask

   task automatic hmodes(input logic cx, input logic hrd, input logic hwr, input logic hb1);
      m_cx = cx; m_hrd = hrd; m_hwr = hwr; m_hb1 = hb1;
   endtask

   task automatic t_reset;
      pg = 8'hC0; wr = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (r_reg !== 7'h00 || b_reg !== 3'd0 || o_reg !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset: actual region=%h bank=%0d ok=%0b expected region=00 bank=0 ok=0",
                  r_reg, b_reg, o_reg);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_io;
      modes(0, 0, 0, 0, 0, 0); hmodes(0, 0, 0, 0);
      probe(8'hC0, 0, E_IO, 0, 0, "R1");
      probe(8'hC0, 1, E_IO, 0, 1, "R1");
      modes(1, 1, 1, 1, 1, 1); hmodes(1, 1, 1, 1);
      probe(8'hC0, 1, E_IO, 0, 1, "R1");
   endtask

   task automatic t_zero_page;
      hmodes(0, 0, 0, 0);
      modes(0, 0, 0, 0, 0, 0);
      probe(8'h00, 0, E_MAIN, 0, 0, "R2");
      probe(8'h01, 1, E_MAIN, 0, 1, "R2");
      modes(0, 0, 1, 0, 0, 0);
      probe(8'h00, 0, E_AUX, 0, 0, "R2");
      probe(8'h01, 1, E_AUX, 0, 1, "R2");
      modes(1, 1, 0, 0, 0, 0);
      probe(8'h00, 0, E_MAIN, 0, 0, "R2");
   endtask

   task automatic t_general;
      hmodes(0, 0, 0, 0);
      modes(1, 0, 0, 0, 0, 0);
      probe(8'h02, 0, E_AUX, 0, 0, "R3");
      probe(8'h02, 1, E_MAIN, 0, 1, "R3");
      probe(8'hBF, 0, E_AUX, 0, 0, "R3");
      modes(0, 1, 0, 0, 0, 0);
      probe(8'h80, 0, E_MAIN, 0, 0, "R3");
      probe(8'hBF, 1, E_AUX, 0, 1, "R3");
      modes(1, 0, 0, 0, 1, 0);
      probe(8'h04, 0, E_AUX, 0, 0, "R4");
   endtask

   task automatic t_text_split;
      hmodes(0, 0, 0, 0);
      modes(1, 1, 0, 1, 0, 0);
      probe(8'h04, 0, E_MAIN, 0, 0, "R4");
      probe(8'h07, 1, E_MAIN, 0, 1, "R4");
      probe(8'h08, 0, E_AUX, 0, 0, "R4");
      modes(0, 0, 0, 1, 1, 0);
      probe(8'h05, 0, E_AUX, 0, 0, "R4");
      probe(8'h06, 1, E_AUX, 0, 1, "R4");
      probe(8'h03, 0, E_MAIN, 0, 0, "R4");
   endtask

   task automatic t_gfx_split;
      hmodes(0, 0, 0, 0);
      modes(0, 0, 0, 1, 1, 1);
      probe(8'h20, 0, E_AUX, 0, 0, "R5");
      probe(8'h3F, 1, E_AUX, 0, 1, "R5");
      probe(8'h40, 0, E_MAIN, 0, 0, "R5");
      modes(1, 1, 0, 1, 0, 1);
      probe(8'h30, 0, E_MAIN, 0, 0, "R5");
      modes(1, 1, 0, 1, 1, 0);
      probe(8'h20, 0, E_MAIN, 0, 0, "R5");
      probe(8'h3F, 1, E_MAIN, 0, 1, "R5");
      modes(1, 0, 0, 1, 0, 0);
      probe(8'h25, 0, E_AUX, 0, 0, "R5");
      probe(8'h25, 1, E_MAIN, 0, 1, "R5");
      modes(0, 0, 0, 0, 1, 1);
      probe(8'h20, 0, E_MAIN, 0, 0, "R5");
   endtask

   task automatic t_rom_window;
      modes(0, 0, 0, 0, 0, 0);
      hmodes(1, 1, 1, 1);
      probe(8'hC1, 0, E_INT, 0, 0, "R6");
      probe(8'hCF, 0, E_INT, 0, 0, "R6");
      hmodes(0, 1, 1, 1);
      probe(8'hC8, 0, E_SLOT, 0, 0, "R6");
      probe(8'hC3, 1, E_NONE, 0, 0, "R6");
   endtask

   task automatic t_high_read;
      modes(0, 0, 0, 0, 0, 0);
      hmodes(0, 1, 0, 1);
      probe(8'hD0, 0, E_HI, 3'd1, 0, "R7");
      probe(8'hDF, 0, E_HI, 3'd1, 0, "R9");
      hmodes(0, 1, 0, 0);
      probe(8'hD5, 0, E_HI, 3'd2, 0, "R9");
      probe(8'hE0, 0, E_HI, 3'd3, 0, "R9");
      probe(8'hFF, 0, E_HI, 3'd3, 0, "R9");
      modes(0, 0, 1, 0, 0, 0);
      hmodes(0, 1, 0, 1);
      probe(8'hD0, 0, E_HI, 3'd5, 0, "R9");
      hmodes(0, 1, 0, 0);
      probe(8'hE8, 0, E_HI, 3'd7, 0, "R9");
      modes(0, 0, 0, 0, 0, 0);
      hmodes(0, 0, 0, 1);
      probe(8'hD0, 0, E_SYS, 0, 0, "R7");
      probe(8'hFF, 0, E_SYS, 0, 0, "R7");
      hmodes(0, 0, 1, 1);
      probe(8'hD0, 0, E_SYS, 0, 0, "R7");
   endtask

   task automatic t_high_write;
      modes(0, 0, 0, 0, 0, 0);
      hmodes(0, 1, 0, 1);
      probe(8'hD0, 1, E_NONE, 0, 0, "R8");
      probe(8'hFF, 1, E_NONE, 0, 0, "R8");
      hmodes(0, 0, 1, 1);
      probe(8'hD2, 1, E_HI, 3'd1, 1, "R8");
      hmodes(0, 0, 1, 0);
      probe(8'hDA, 1, E_HI, 3'd2, 1, "R8");
      probe(8'hF0, 1, E_HI, 3'd3, 1, "R9");
      modes(0, 0, 1, 0, 0, 0);
      probe(8'hE0, 1, E_HI, 3'd7, 1, "R9");
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      t_reset();
      t_io();
      t_zero_page();
      t_general();
      t_text_split();
      t_gfx_split();
      t_rom_window();
      t_high_read();
      t_high_write();
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

endmodule